// File: doc/BRIEF.md
# Saturating Windowed Measurement Counter

This block tallies quality or error events produced by a demodulator datapath. A 16-bit counter accumulates one per cycle on which the event strobe is high. The counter saturates at full scale instead of wrapping. A separate sample-valid strobe paces the measurement window. In fixed mode the window closes after a programmed number of samples and raises a done flag. In open mode the measurement runs until software restarts it, and the running count can be read at any moment.

Control comes from a register-style interface: a start pulse, a mode bit and a 2-bit window-size field. The start pulse clears the count and re-arms the window. The done flag is write-1-to-clear. It reaches the interrupt pin only when the interrupt enable is set. Producing the events, converting a count into a figure of merit, and the register bus itself are all outside this block.

Top module: `meas_win_counter`

## Requirements
- R1: While reset is high and in the cycle after it, `count_o` is 0 and `busy_o`, `done_flag_o`, `irq_o` and `start_flag_o` are all 0.
- R2: A cycle with `start_i` high clears the count, so `count_o` reads 0 in the next cycle. This holds even when running, and `event_i` and `sample_i` on that same cycle are ignored. The start also sets `busy_o`.
- R3: `start_flag_o` reads 1 in exactly the cycle after a start is accepted, and 0 in every other cycle.
- R4: With `open_win_i` low at start, the window lasts 2^(10+n) accepted samples, where n is `win_sel_i` captured at start: 0→1024, 1→2048, 2→4096, 3→8192. Changes to `win_sel_i` during a run have no effect. In the cycle after the edge that accepts the last sample, `busy_o` is 0 and `done_flag_o` is 1.
- R5: While measuring, `count_o` rises by one for each cycle with `event_i` high, including the cycle of the last sample. Events while idle leave the count unchanged.
- R6: The count stops at 65535 and holds there; it never wraps.
- R7: With `open_win_i` high at start, `busy_o` stays 1 regardless of the number of samples, no done flag is raised, and `count_o` tracks events continuously.
- R8: `done_flag_o` stays set until a cycle with `done_clr_i` high, after which it reads 0.
- R9: `irq_o` is 1 exactly when `done_flag_o` and `irq_en_i` are both 1.
- R10: A start during a fixed run re-arms the window, and the full window length is counted again from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: clear count, arm window |
| open_win_i | input | 1 | Mode at start: 1 = open window, 0 = fixed window |
| win_sel_i | input | 2 | Fixed window size select n, length 2^(10+n) samples |
| sample_i | input | 1 | Sample-valid strobe that advances the window |
| event_i | input | 1 | Event strobe to be counted |
| irq_en_i | input | 1 | Interrupt enable |
| done_clr_i | input | 1 | Write-1-to-clear for the done flag |
| count_o | output | 16 | Saturating event count |
| busy_o | output | 1 | Measurement in progress |
| start_flag_o | output | 1 | Start bit readback, self-clearing |
| done_flag_o | output | 1 | Window-complete status |
| irq_o | output | 1 | Interrupt output |

## Verification
Several properties are checked on every cycle:
- the count changes only by +1 or by clearing, and stays still while idle or at full scale;
- the start readback is a one-cycle pulse;
- the done flag rises only out of a busy measurement, and is held until cleared;
- the interrupt never fires without a done flag.

Other behaviour only the bench scenarios can show: that a window ends after exactly 2^(10+n) samples for each size, that the count at completion matches the events sent, and that a mid-run restart buys a full fresh window. Saturation after tens of thousands of events and the absence of done in open mode also need those scenarios.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    localparam int CNT_W     = 16;
    localparam int BASE_LOG2 = 10;
    localparam int SEL_W     = 2;
    // enough bits to index the longest window
    localparam int WIN_CW    = BASE_LOG2 + (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_OPEN  = 2'd2
    } run_st_e;

    typedef struct packed {
        logic             open_win;
        logic [SEL_W-1:0] sel;
    } win_cfg_t;

    // index of the final sample for a window select value
    function automatic logic [WIN_CW-1:0] last_index(input logic [SEL_W-1:0] sel,
                                                     input int base_log2);
        logic [63:0] len;
        len = 64'd1 << (base_log2 + int'(sel));
        return WIN_CW'(len - 64'd1);
    endfunction

endpackage

// File: rtl/mwc_ctrl.sv
module mwc_ctrl
    import mwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  win_cfg_t cfg_i,
    input  logic     win_end_i,
    output run_st_e  state_o,
    output win_cfg_t cfg_q_o,
    output logic     start_flag_o
);

    run_st_e  state_q;
    win_cfg_t cfg_q;
    logic     flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            flag_q <= start_i;
            if (start_i) begin
                cfg_q   <= cfg_i;
                state_q <= cfg_i.open_win ? ST_OPEN : ST_FIXED;
            end else if (state_q == ST_FIXED && win_end_i) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign state_o      = state_q;
    assign cfg_q_o      = cfg_q;
    assign start_flag_o = flag_q;

endmodule

// File: rtl/mwc_window.sv
module mwc_window
    import mwc_pkg::*;
#(
    parameter int BASE_LOG2_P = mwc_pkg::BASE_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             run_fixed_i,
    input  logic             sample_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             win_end_o
);

    logic [WIN_CW-1:0] idx_q;
    logic [WIN_CW-1:0] lim;
    logic              step;

    always_comb begin
        lim       = last_index(sel_i, BASE_LOG2_P);
        step      = run_fixed_i && sample_i && !start_i;
        win_end_o = step && (idx_q == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= win_end_o ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/mwc_accum.sv
module mwc_accum #(
    parameter int CNT_W_P = mwc_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               inc_i,
    output logic [CNT_W_P-1:0] count_o
);

    localparam logic [CNT_W_P-1:0] FULL = {CNT_W_P{1'b1}};

    logic [CNT_W_P-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/mwc_irq.sv
module mwc_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            // a completing window outranks a clear on the same cycle
            flag_q <= set_i | (flag_q & ~clr_i);
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

endmodule

// File: rtl/meas_win_counter.sv
module meas_win_counter
    import mwc_pkg::*;
#(
    parameter int CNT_W_P     = mwc_pkg::CNT_W,
    parameter int BASE_LOG2_P = mwc_pkg::BASE_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               open_win_i,
    input  logic [SEL_W-1:0]   win_sel_i,
    input  logic               sample_i,
    input  logic               event_i,
    input  logic               irq_en_i,
    input  logic               done_clr_i,
    output logic [CNT_W_P-1:0] count_o,
    output logic               busy_o,
    output logic               start_flag_o,
    output logic               done_flag_o,
    output logic               irq_o
);

    win_cfg_t cfg_in;
    win_cfg_t cfg_q;
    run_st_e  state;
    logic     win_end;
    logic     measuring;

    always_comb begin
        cfg_in.open_win = open_win_i;
        cfg_in.sel      = win_sel_i;
        measuring       = (state != ST_IDLE);
    end

    mwc_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cfg_i        (cfg_in),
        .win_end_i    (win_end),
        .state_o      (state),
        .cfg_q_o      (cfg_q),
        .start_flag_o (start_flag_o)
    );

    mwc_window #(.BASE_LOG2_P(BASE_LOG2_P)) win_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .run_fixed_i (state == ST_FIXED),
        .sample_i    (sample_i),
        .sel_i       (cfg_q.sel),
        .win_end_o   (win_end)
    );

    mwc_accum #(.CNT_W_P(CNT_W_P)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .inc_i   (measuring && event_i),
        .count_o (count_o)
    );

    mwc_irq irq_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (win_end),
        .clr_i  (done_clr_i),
        .en_i   (irq_en_i),
        .flag_o (done_flag_o),
        .irq_o  (irq_o)
    );

    assign busy_o = measuring;

endmodule

// File: rtl/mwc_checker.sv
module mwc_checker #(
    parameter int CNT_W_P = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               done_clr_i,
    input logic [CNT_W_P-1:0] count_o,
    input logic               busy_o,
    input logic               start_flag_o,
    input logic               done_flag_o,
    input logic               irq_o
);

    localparam logic [CNT_W_P-1:0] FULL = {CNT_W_P{1'b1}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !busy_o && !done_flag_o && !start_flag_o));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (count_o == '0 && busy_o));

    // R3
    start_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> start_flag_o);

    // R3
    start_flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !start_flag_o);

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(count_o));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (count_o == FULL && !start_i) |=> count_o == FULL);

    // R4
    done_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag_o) |-> $past(busy_o));

    // R4
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(start_i)) |-> done_flag_o);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_flag_o && !done_clr_i) |=> done_flag_o);

    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> done_flag_o);

endmodule

bind meas_win_counter mwc_checker #(.CNT_W_P(CNT_W_P)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .done_clr_i   (done_clr_i),
    .count_o      (count_o),
    .busy_o       (busy_o),
    .start_flag_o (start_flag_o),
    .done_flag_o  (done_flag_o),
    .irq_o        (irq_o)
);

// File: tb/meas_win_counter_tb_top.sv
`timescale 1ns/1ps
module meas_win_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, open_win_i = 0, sample_i = 0, event_i = 0;
    logic        irq_en_i = 0, done_clr_i = 0;
    logic [1:0]  win_sel_i = 0;
    logic [15:0] count_o;
    logic        busy_o, start_flag_o, done_flag_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    meas_win_counter dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .open_win_i(open_win_i),
        .win_sel_i(win_sel_i), .sample_i(sample_i), .event_i(event_i),
        .irq_en_i(irq_en_i), .done_clr_i(done_clr_i), .count_o(count_o),
        .busy_o(busy_o), .start_flag_o(start_flag_o), .done_flag_o(done_flag_o),
        .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int win_len(input int sel);
        return 1 << (10 + sel);
    endfunction

    function automatic int sat_add(input int a);
        return (a >= 65535) ? 65535 : a + 1;
    endfunction

    function automatic bit roll(input int pct);
        return $urandom_range(99) < pct;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    // start pulse with noisy strobes that must be ignored
    task automatic pulse_start(input bit open_w, input int sel);
        start_i = 1; open_win_i = open_w; win_sel_i = 2'(sel);
        event_i = 1; sample_i = 1;
        tick();
        start_i = 0; event_i = 0; sample_i = 0;
        chk(start_flag_o == 1, "R3 flag after start", start_flag_o, 1);
        chk(count_o == 0, "R2 count cleared, start-cycle event ignored", count_o, 0);
        chk(busy_o == 1, "R2 busy after start", busy_o, 1);
        tick();
        chk(start_flag_o == 0, "R3 flag self-clears", start_flag_o, 0);
    endtask

    // fixed window; the counts for the flag-clear cycle are already folded in
    task automatic run_fixed(input int sel, input int ev_pct, input int sv_pct);
        int n = win_len(sel);
        int exp = 0;
        int seen = 0;
        pulse_start(0, sel);
        win_sel_i = 2'(3 - sel); // R4: must be ignored mid-run
        while (seen < n) begin
            event_i  = roll(ev_pct);
            sample_i = roll(sv_pct);
            if (event_i) exp = sat_add(exp);
            if (sample_i) seen++;
            tick();
            if (seen == n - 1 && sample_i)
                chk(busy_o == 1 && done_flag_o == 0, "R4 still busy before last sample", busy_o, 1);
        end
        event_i = 0; sample_i = 0;
        chk(busy_o == 0, "R4 busy drops after window", busy_o, 0);
        chk(done_flag_o == 1, "R4 done after window", done_flag_o, 1);
        chk(count_o == 16'(exp), "R5 count equals events in window", count_o, exp);
        for (int i = 0; i < 8; i++) begin
            event_i = 1; sample_i = roll(50);
            tick();
        end
        event_i = 0; sample_i = 0;
        chk(count_o == 16'(exp), "R5 idle events ignored", count_o, exp);
        chk(done_flag_o == 1, "R8 done held", done_flag_o, 1);
    endtask

    task automatic clear_done();
        done_clr_i = 1;
        tick();
        done_clr_i = 0;
        chk(done_flag_o == 0, "R8 write-1 clears done", done_flag_o, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        tick(); tick(); tick();
        chk(count_o == 0 && busy_o == 0 && done_flag_o == 0 && irq_o == 0 && start_flag_o == 0,
            "R1 reset state", {count_o, busy_o, done_flag_o, irq_o, start_flag_o}, 0);
        rst = 0;
        tick();
        chk(count_o == 0 && busy_o == 0, "R1 after release", count_o, 0);

        // all four window sizes
        run_fixed(0, 40, 50);
        chk(irq_o == 0, "R9 irq masked", irq_o, 0);
        irq_en_i = 1;
        #1;
        chk(irq_o == 1, "R9 irq with enable", irq_o, 1);
        clear_done();
        #1;
        chk(irq_o == 0, "R9 irq after clear", irq_o, 0);
        irq_en_i = 0;
        run_fixed(1, 70, 100);
        clear_done();
        run_fixed(2, 15, 100);
        clear_done();
        run_fixed(3, 90, 100);
        clear_done();

        // R10: restart in the middle of a fixed window
        pulse_start(0, 0);
        for (int i = 0; i < 600; i++) begin
            event_i = 1; sample_i = 1;
            tick();
        end
        chk(count_o == 600 && busy_o == 1, "R10 partial run", count_o, 600);
        run_fixed(0, 60, 80);
        clear_done();

        // R7 / R6: open window, then saturate
        pulse_start(1, 0);
        for (int i = 0; i < 1000; i++) begin
            event_i = 1; sample_i = 1;
            tick();
        end
        chk(count_o == 1000, "R7 open count readable", count_o, 1000);
        chk(busy_o == 1 && done_flag_o == 0, "R7 open busy, no done", busy_o, 1);
        for (int i = 0; i < 65000; i++) begin
            event_i = 1; sample_i = roll(90);
            tick();
        end
        chk(count_o == 65535, "R6 saturates", count_o, 65535);
        chk(busy_o == 1 && done_flag_o == 0, "R7 never ends", done_flag_o, 0);
        event_i = 1;
        tick(); tick();
        chk(count_o == 65535, "R6 no wrap", count_o, 65535);
        event_i = 0;
        pulse_start(1, 2);
        chk(count_o == 0, "R2 restart from saturation clears", count_o, 0);
        run_fixed(0, 50, 100);
        clear_done();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule